// File: doc/BRIEF.md
# Bit-Serial Barrel Shifter

This unit shifts 16-bit words that reach it one bit per clock, least significant bit first. A strobe marks the first bit of each word. In that same cycle the unit takes a shift amount and two mode flags: direction and arithmetic fill. It then sends out the shifted word as a serial stream with its own first-bit strobe. The output strobe follows the input strobe by exactly 16 cycles, whatever the mode.

The unit does no parallel muxing across a word. Every input bit enters a tapped delay line. Each output bit is read from the tap whose age fits the shift amount. A left shift reads an older tap and masks the leading bits to zero. A right shift reads a younger tap and puts fill into the trailing bits. The sign bit is the last bit of a word to arrive, so output starts only after the whole word has been taken in. Words may follow one another with no idle cycles between them.

Top module: `serial_shifter`

## Requirements
- R1: While reset is active, and at any time no output word is in progress, `dout_o` and `ostart_o` are 0.
- R2: A word is input bit 0 in the cycle where `start_i` is high, then bits 1 to 15 in the following 15 cycles. `ostart_o` goes high exactly 16 cycles after `start_i`, for one cycle, together with output bit 0. Output bits 1 to 15 follow in the next 15 cycles, and `ostart_o` stays low during them.
- R3: With `right_i`=0 and amount n = `amt_i[3:0]` (upper amount bits zero), output bit k is 0 for k < n and input bit k-n otherwise.
- R4: With `right_i`=1 and `arith_i`=0 (upper amount bits zero), output bit k is input bit k+n when k+n < 16, and 0 otherwise.
- R5: With `right_i`=1 and `arith_i`=1 (upper amount bits zero), output bit k is input bit k+n when k+n < 16, and otherwise input bit 15 (the sign).
- R6: For either logical shift, any set bit in `amt_i[15:4]` makes the output word all zeros.
- R7: For the arithmetic right shift, any set bit in `amt_i[15:4]` makes the output word 16 copies of input bit 15.
- R8: When `right_i`=0, `arith_i` has no effect on the output word.
- R9: `amt_i`, `right_i` and `arith_i` are sampled only in the `start_i` cycle. Changes to them during bits 1 to 15 have no effect.
- R10: A new word may start in the cycle right after bit 15 of the previous word. Each word then gives its own output word, and the output words come back to back.
- R11: If `start_i` is asserted before bit 15 of a word has been taken in, that partial word is dropped. It produces no output word, and the new strobe starts a fresh word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | High with bit 0 of an input word |
| din_i | input | 1 | Serial data in, LSB first |
| amt_i | input | 16 | Shift amount, sampled with `start_i` |
| right_i | input | 1 | 1 = shift right, 0 = shift left; sampled with `start_i` |
| arith_i | input | 1 | 1 = sign fill on right shift; sampled with `start_i` |
| dout_o | output | 1 | Serial data out, LSB first |
| ostart_o | output | 1 | High with bit 0 of an output word |

## Verification
A wrong tap index shows up as a word that has slipped by one or more places at the boundary between shifted and fill bits. It appears within the 16 output cycles of that word, 16 cycles after its strobe. A wrong bit counter or a wrong handoff moves `ostart_o` away from the 16-cycle point, or loses or duplicates whole words. This is most visible when words run back to back or a word is cut short. A sign capture taken from the wrong cycle corrupts only the fill bits of arithmetic shifts, so the bench uses words that differ in their top and bottom bits.

// File: rtl/serial_shift_pkg.sv
package serial_shift_pkg;

  // Mode of one word, frozen at its start strobe
  typedef struct packed {
    logic right;  // 1 = toward LSB
    logic arith;  // sign fill on right shift
    logic ovr;    // amount has a bit above the count field
  } shift_mode_t;

endpackage

// File: rtl/ss_in_ctrl.sv
module ss_in_ctrl
  import serial_shift_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int AMT_W  = 16,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              right_i,
  input  logic              arith_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic              last_o,
  output shift_mode_t       mode_o,
  output logic [CNT_W-1:0]  n_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  shift_mode_t      mode_q;
  logic [CNT_W-1:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= '0;
      n_q    <= '0;
    end else if (start_i) begin
      // a strobe always opens a fresh word
      busy_q       <= 1'b1;
      cnt_q        <= CNT_W'(1);
      mode_q.right <= right_i;
      mode_q.arith <= arith_i;
      mode_q.ovr   <= |amt_i[AMT_W-1:CNT_W];
      n_q          <= amt_i[CNT_W-1:0];
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign last_o = busy_q && (cnt_q == LAST) && !start_i;
  assign mode_o = mode_q;
  assign n_o    = n_q;

  // R11
  restart_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && cnt_q == CNT_W'(1)));

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i) |=> ($stable(mode_q) && $stable(n_q)));

endmodule

// File: rtl/ss_tap_line.sv
module ss_tap_line #(
  parameter int DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_i,
  output logic [DEPTH-1:0] hist_o
);

  // hist_o[i] holds the bit sampled i+1 edges ago
  logic [DEPTH-1:0] stage_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_head
      assign d = din_i;
    end else begin : g_body
      assign d = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b0;
      else         stage_q[g] <= d;
    end
  end

  assign hist_o = stage_q;

endmodule

// File: rtl/ss_out_seq.sv
module ss_out_seq
  import serial_shift_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  shift_mode_t       mode_i,
  input  logic [CNT_W-1:0]  n_i,
  input  logic              din_i,
  output logic              active_o,
  output logic              first_o,
  output logic [CNT_W-1:0]  cnt_o,
  output shift_mode_t       mode_o,
  output logic [CNT_W-1:0]  n_o,
  output logic              sign_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  shift_mode_t      mode_q;
  logic [CNT_W-1:0] n_q;
  logic             sign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      mode_q   <= '0;
      n_q      <= '0;
      sign_q   <= 1'b0;
    end else if (load_i) begin
      // din_i carries the top input bit in the load cycle
      active_q <= 1'b1;
      cnt_q    <= '0;
      mode_q   <= mode_i;
      n_q      <= n_i;
      sign_q   <= din_i;
    end else if (active_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == LAST) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign first_o  = active_q && (cnt_q == '0);
  assign cnt_o    = cnt_q;
  assign mode_o   = mode_q;
  assign n_o      = n_q;
  assign sign_o   = sign_q;

  // R10
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (first_o && sign_q == $past(din_i)));

  // R2
  strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |=> !first_o);

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !load_i && cnt_q != LAST) |=> (active_q && cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/ss_out_mux.sv
module ss_out_mux
  import serial_shift_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 2 * WORD_W,
  parameter int CNT_W  = $clog2(WORD_W),
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              active_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  shift_mode_t       mode_i,
  input  logic [CNT_W-1:0]  n_i,
  input  logic              sign_i,
  input  logic [DEPTH-1:0]  hist_i,
  output logic              bit_o
);

  logic [IDX_W-1:0] idx_left;
  logic [IDX_W-1:0] idx_right;
  logic [CNT_W:0]   pos_sum;
  logic             fill;

  // left: tap older by n, right: tap younger by n
  assign idx_left  = IDX_W'(WORD_W - 1) + IDX_W'(n_i);
  assign idx_right = IDX_W'(WORD_W - 1) - IDX_W'(n_i);
  assign pos_sum   = {1'b0, cnt_i} + {1'b0, n_i};
  assign fill      = mode_i.arith & sign_i;

  always_comb begin
    bit_o = 1'b0;
    if (active_i) begin
      if (mode_i.ovr) begin
        bit_o = mode_i.right & fill;
      end else if (mode_i.right) begin
        if (pos_sum < (CNT_W+1)'(WORD_W)) bit_o = hist_i[idx_right];
        else                              bit_o = fill;
      end else begin
        if (cnt_i < n_i) bit_o = 1'b0;
        else             bit_o = hist_i[idx_left];
      end
    end
  end

endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
  import serial_shift_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int AMT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             din_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             right_i,
  input  logic             arith_i,
  output logic             dout_o,
  output logic             ostart_o
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam int DEPTH = 2 * WORD_W;
  localparam int IDX_W = $clog2(DEPTH);

  logic             last_w;
  shift_mode_t      in_mode_w;
  logic [CNT_W-1:0] in_n_w;
  logic [DEPTH-1:0] hist_w;
  logic             active_w;
  logic             first_w;
  logic [CNT_W-1:0] cnt_w;
  shift_mode_t      out_mode_w;
  logic [CNT_W-1:0] out_n_w;
  logic             sign_w;
  logic             bit_w;

  ss_in_ctrl #(.WORD_W(WORD_W), .AMT_W(AMT_W), .CNT_W(CNT_W)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .right_i (right_i),
    .arith_i (arith_i),
    .amt_i   (amt_i),
    .last_o  (last_w),
    .mode_o  (in_mode_w),
    .n_o     (in_n_w)
  );

  ss_tap_line #(.DEPTH(DEPTH)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (din_i),
    .hist_o (hist_w)
  );

  ss_out_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (last_w),
    .mode_i   (in_mode_w),
    .n_i      (in_n_w),
    .din_i    (din_i),
    .active_o (active_w),
    .first_o  (first_w),
    .cnt_o    (cnt_w),
    .mode_o   (out_mode_w),
    .n_o      (out_n_w),
    .sign_o   (sign_w)
  );

  ss_out_mux #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_mux (
    .active_i (active_w),
    .cnt_i    (cnt_w),
    .mode_i   (out_mode_w),
    .n_i      (out_n_w),
    .sign_i   (sign_w),
    .hist_i   (hist_w),
    .bit_o    (bit_w)
  );

  assign dout_o   = bit_w;
  assign ostart_o = first_w;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_w |-> (!dout_o && !ostart_o));

  // R6
  ovr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_w && out_mode_w.ovr && !(out_mode_w.right && out_mode_w.arith)) |-> !dout_o);

  // R5
  sign_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_w && out_mode_w.right && out_mode_w.arith && cnt_w == CNT_W'(WORD_W - 1))
      |-> (dout_o == sign_w));

endmodule

// File: tb/sim_serial_shifter.sv
module sim_serial_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         din_i = 1'b0;
  logic [W-1:0] amt_i = '0;
  logic         right_i = 1'b0;
  logic         arith_i = 1'b0;
  logic         dout_o;
  logic         ostart_o;

  serial_shifter #(.WORD_W(W), .AMT_W(W)) u0 (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .din_i    (din_i),
    .amt_i    (amt_i),
    .right_i  (right_i),
    .arith_i  (arith_i),
    .dout_o   (dout_o),
    .ostart_o (ostart_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] exp_q[$];
  int           t_q[$];
  string        tag_q[$];

  function automatic logic [W-1:0] model(logic [W-1:0] w, logic [W-1:0] a, logic r, logic ar);
    logic ovr = |a[W-1:4];
    if (!r)       return ovr ? '0 : (w << a[3:0]);
    else if (!ar) return ovr ? '0 : (w >> a[3:0]);
    else          return ovr ? {W{w[W-1]}} : W'($signed(w) >>> a[3:0]);
  endfunction

  task automatic send_word(input logic [W-1:0] w, input logic [W-1:0] a,
                           input logic r, input logic ar, input string tag);
    exp_q.push_back(model(w, a, r, ar));
    t_q.push_back(cyc);
    tag_q.push_back(tag);
    for (int j = 0; j < W; j++) begin
      start_i = (j == 0);
      din_i   = w[j];
      // R9: scramble mode inputs after the strobe cycle
      amt_i   = (j == 0) ? a  : W'($urandom);
      right_i = (j == 0) ? r  : 1'($urandom);
      arith_i = (j == 0) ? ar : 1'($urandom);
      @(negedge clk);
    end
    start_i = 1'b0;
    din_i   = 1'($urandom);
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      din_i = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic partial_word(input int nb);
    for (int j = 0; j < nb; j++) begin
      start_i = (j == 0);
      din_i   = 1'($urandom);
      amt_i   = W'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // monitor / scoreboard
  initial begin : monitor
    logic [W-1:0] got;
    logic [W-1:0] exp;
    int           t0;
    int           ts;
    string        tag;
    bit           strobe_bad;
    wait (rst_ni);
    forever begin
      @(negedge clk);
      if (ostart_o) begin
        got[0]     = dout_o;
        t0         = cyc;
        strobe_bad = 1'b0;
        for (int j = 1; j < W; j++) begin
          @(negedge clk);
          got[j] = dout_o;
          if (ostart_o) strobe_bad = 1'b1;
        end
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R11 unexpected output word: got %h, expected none", got);
        end else begin
          exp = exp_q.pop_front();
          ts  = t_q.pop_front();
          tag = tag_q.pop_front();
          if (got !== exp) begin
            n_bad++;
            $display("FAIL %s word: got %h, expected %h", tag, got, exp);
          end
          n_chk++;
          if (t0 - ts != W || strobe_bad) begin
            n_bad++;
            $display("FAIL R2 strobe latency: got %0d (extra strobe %0d), expected %0d (0)",
                     t0 - ts, strobe_bad, W);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: got no end of run, expected end within limit");
    summary();
    $finish;
  end

  logic [W-1:0] pats[4] = '{16'hA5C3, 16'h8001, 16'h7FFE, 16'hC0DE};

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1 during reset
    n_chk++;
    if (dout_o !== 1'b0 || ostart_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got %b%b, expected 00", dout_o, ostart_o);
    end
    rst_ni = 1'b1;
    idle(4);
    // R1 idle after reset
    n_chk++;
    if (dout_o !== 1'b0 || ostart_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 idle: got %b%b, expected 00", dout_o, ostart_o);
    end

    // R3 R4 R5 sweep of all counts, back to back (R10)
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < W; n++) send_word(pats[p], W'(n), 1'b0, 1'b0, "R3 left");
      for (int n = 0; n < W; n++) send_word(pats[p], W'(n), 1'b1, 1'b0, "R4 logical right");
      for (int n = 0; n < W; n++) send_word(pats[p], W'(n), 1'b1, 1'b1, "R5 arith right");
    end
    idle(3);

    // R6 R7 upper amount bits
    send_word(16'hFFFF, 16'h0010, 1'b0, 1'b0, "R6 left over-range");
    send_word(16'hFFFF, 16'h8003, 1'b1, 1'b0, "R6 right over-range");
    send_word(16'h8421, 16'hFFFF, 1'b1, 1'b1, "R7 arith over-range neg");
    send_word(16'h7BDE, 16'h0100, 1'b1, 1'b1, "R7 arith over-range pos");
    idle(2);

    // R8 arith flag on left shift
    send_word(16'h8F0F, 16'd4, 1'b0, 1'b1, "R8 left arith flag");
    send_word(16'hFFFF, 16'h0020, 1'b0, 1'b1, "R8 left arith over-range");
    idle(5);

    // R11 aborted words
    partial_word(5);
    send_word(16'h1234, 16'd3, 1'b1, 1'b1, "R11 restart");
    partial_word(15);
    send_word(16'hF00D, 16'd7, 1'b0, 1'b0, "R11 restart late");
    idle(1);

    // R9 R10 random words with random gaps
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a;
      a = (i % 5 == 0) ? W'($urandom) : W'($urandom % W);
      send_word(W'($urandom), a, 1'($urandom), 1'($urandom), "R9 random");
      idle($urandom % 3);
    end

    idle(2 * W + 8);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10 missing words: got %0d pending, expected 0", exp_q.size());
    end
    summary();
    $finish;
  end

endmodule